// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the digital core of a serial EEPROM that answers on a two-wire bus (SCL clock, SDA data). It watches the bus for start and stop conditions. It answers a 7-bit device address made of the fixed type code `1010` followed by three strap inputs. Once addressed, it accepts a two-byte memory address and then either collects write data or returns read data. The memory is a byte-wide register array of `2**ADDR_W` locations split into 64-byte pages. Use `ADDR_W` of 14 or 15 for the 16384-byte and 32768-byte sizes. The default is kept smaller so that elaboration stays light.

Write data does not go straight to the array. It lands in a 64-entry page latch, and only a stop condition starts the internal program cycle. That cycle lasts `WR_CYCLES` clocks and copies every latched byte into the addressed page. While the cycle runs, the device refuses its own address, so a master can poll for completion by sending address bytes. A write-protect input held high at the stop prevents any program cycle.

The bus pins are sampled with the system clock through a small synchronizer, so SCL must stay low and high for several system clocks per phase. SDA is open-drain: `sda_oe` high means the block pulls the line low. The external pull-up supplies the high level.

Top module: `eep_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and no program cycle is running, so the first correct device address is acknowledged.
- R2: A device address byte is acknowledged only when bits 7..4 equal `1010` and bits 3..1 equal `strap_i[2:0]`; bit 0 selects read (1) or write (0). Any other address gets no acknowledge.
- R3: Every byte the addressed device receives (device address, both memory address bytes, write data) is acknowledged by pulling SDA low for the ninth SCL clock, also when `wp_i` is high.
- R4: The memory address comes as two bytes, high byte first; address bits at or above `ADDR_W` are ignored.
- R5: A single-byte write changes exactly the addressed location and leaves its neighbours unchanged.
- R6: Write data fills the page latch starting at the address's low 6 bits and wraps modulo 64 inside the page; a later byte for the same slot replaces the earlier one; all latched bytes are programmed in one cycle.
- R7: A stop after at least one write data byte starts a program cycle of `WR_CYCLES` clocks; during it the device address is not acknowledged, and afterwards it is again.
- R8: With `wp_i` high at the stop, no location changes and no program cycle starts (the device address is acknowledged right away).
- R9: A write of the two address bytes, a repeated start and a read address byte returns the byte stored at that address.
- R10: While the master acknowledges, a read continues with the next address across page boundaries, wrapping from the last location to 0.
- R11: A master no-acknowledge after a read byte makes the device release SDA and drive nothing more until the next start.
- R12: `sda_oe` changes only while the synchronized SCL is low, so the device never makes a start or stop on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | 1 blocks every array update |

## Verification
The bench runs directed transfers: wrong type code and wrong strap addresses, a byte write through an address with junk upper bits that sits between two known neighbours, and a 70-byte page write that wraps and overwrites inside one page. It also runs a protected write followed by an immediate poll, and a two-byte read that wraps from the top of the array. Address polling directly after a stop tells a running program cycle apart from an idle one. The page readback tells slot wrapping apart from linear addressing. Seeded random byte-run writes at random addresses and pages, each read back through a random read, catch wrong address assembly and wrong latch-to-array mapping.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int          PAGE_BYTES = 64;
    localparam int          PAGE_W     = 6;
    localparam logic [3:0]  DEV_TYPE   = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_TYPE, strap};
    endfunction

endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense
    import eep_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [SYNC-1:0] scl_sh, sda_sh;
    logic            scl_p, sda_p;
    logic            scl_c, sda_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC-2:0], sda_i};
            scl_p  <= scl_sh[SYNC-1];
            sda_p  <= sda_sh[SYNC-1];
        end
    end

    assign scl_c = scl_sh[SYNC-1];
    assign sda_c = sda_sh[SYNC-1];

    always_comb begin
        ev.scl      = scl_c;
        ev.sda      = sda_c;
        ev.scl_rise = scl_c && !scl_p;
        ev.scl_fall = !scl_c && scl_p;
        ev.start    = scl_p && scl_c && sda_p && !sda_c;
        ev.stop     = scl_p && scl_c && !sda_p && sda_c;
    end

endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata,
    output logic          rvld,
    output logic          any
);

    logic [7:0]   lat_q [N];
    logic [N-1:0] vld_q;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [7:0] q;
        logic       v;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
                v <= 1'b0;
            end else if (clr) begin
                v <= 1'b0;
            end else if (we && widx == IW'(g)) begin
                q <= wdata;
                v <= 1'b1;
            end
        end
        assign lat_q[g] = q;
        assign vld_q[g] = v;
    end

    assign rdata = lat_q[ridx];
    assign rvld  = vld_q[ridx];
    assign any   = |vld_q;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int WR_CYCLES  = 500,
    parameter int PAGE_BYTES = 64,
    parameter int IW         = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    output logic          busy,
    output logic          cen,
    output logic [IW-1:0] cidx
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(WR_CYCLES - 1)) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign cen  = busy && (cnt < CW'(PAGE_BYTES));
    assign cidx = cnt[IW-1:0];

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int WR_CYCLES = 500,
    parameter int SYNC      = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int PG_W = ADDR_W - PAGE_W;

    bus_ev_t           ev;
    phase_t            st;
    logic [3:0]        bcnt;
    logic [7:0]        shreg, txb, ahi;
    logic [ADDR_W-1:0] ptr;
    logic [PG_W-1:0]   pg;
    logic              m_ack, rd_first;

    logic              byte_done, lat_we, lat_clr, lat_any, lat_vld;
    logic [7:0]        lat_rd, arr_rd;
    logic              busy, cen, arr_we, prog_go;
    logic [PAGE_W-1:0] cidx;

    eep_bus_sense #(.SYNC(SYNC)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign byte_done = ev.scl_fall && bcnt == 4'd8;
    assign lat_we    = byte_done && st == ST_WDATA;
    assign lat_clr   = byte_done && st == ST_ALO;
    assign prog_go   = ev.stop && st == ST_WDATA && lat_any && !wp_i && !busy;

    eep_page_latch #(.N(PAGE_BYTES), .IW(PAGE_W)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .clr   (lat_clr),
        .we    (lat_we),
        .widx  (ptr[PAGE_W-1:0]),
        .wdata (shreg),
        .ridx  (cidx),
        .rdata (lat_rd),
        .rvld  (lat_vld),
        .any   (lat_any)
    );

    eep_prog_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES), .IW(PAGE_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (prog_go),
        .busy (busy),
        .cen  (cen),
        .cidx (cidx)
    );

    assign arr_we = cen && lat_vld;

    eep_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({pg, cidx}),
        .wdata (lat_rd),
        .raddr (ptr),
        .rdata (arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bcnt     <= '0;
            shreg    <= '0;
            txb      <= '0;
            ahi      <= '0;
            ptr      <= '0;
            pg       <= '0;
            m_ack    <= 1'b0;
            rd_first <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            if (prog_go) begin
                pg <= ptr[ADDR_W-1:PAGE_W];
            end
            if (ev.start) begin
                st     <= ST_DEV;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (ev.scl_rise) begin
                if (bcnt < 4'd8) begin
                    shreg <= {shreg[6:0], ev.sda};
                    bcnt  <= bcnt + 4'd1;
                end else if (bcnt == 4'd8) begin
                    bcnt  <= 4'd9;
                    m_ack <= !ev.sda;
                end
            end else if (ev.scl_fall) begin
                if (bcnt == 4'd9) begin
                    bcnt   <= '0;
                    sda_oe <= 1'b0;
                    if (st == ST_RDATA) begin
                        if (rd_first || m_ack) begin
                            txb      <= arr_rd;
                            sda_oe   <= !arr_rd[7];
                            ptr      <= ptr + ADDR_W'(1);
                            rd_first <= 1'b0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end else if (bcnt == 4'd8) begin
                    sda_oe <= 1'b0;
                    case (st)
                        ST_DEV: begin
                            if (dev_hit(shreg, strap_i) && !busy) begin
                                sda_oe <= 1'b1;
                                if (shreg[0]) begin
                                    st       <= ST_RDATA;
                                    rd_first <= 1'b1;
                                end else begin
                                    st <= ST_AHI;
                                end
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_AHI: begin
                            ahi    <= shreg;
                            sda_oe <= 1'b1;
                            st     <= ST_ALO;
                        end
                        ST_ALO: begin
                            ptr    <= ADDR_W'({ahi, shreg});
                            sda_oe <= 1'b1;
                            st     <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                            sda_oe <= 1'b1;
                        end
                        default: ;
                    endcase
                end else if (st == ST_RDATA && bcnt != 4'd0) begin
                    sda_oe <= !txb[3'd7 - bcnt[2:0]];
                end
            end
        end
    end

    // R7: a busy device never acknowledges its device address
    a_r7_nack_when_busy: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && byte_done && busy) |=> !sda_oe);

    // R12: SDA drive only moves while SCL is low
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);

    // R11: master no-acknowledge ends driving
    a_r11_release_on_nack: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDATA && ev.scl_fall && bcnt == 4'd9 && !rd_first && !m_ack) |=> !sda_oe);

    // R8: protected stop never starts the timer
    a_r8_wp_blocks_cycle: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && wp_i && !busy) |=> !busy);

    // R6: latched data with write enabled starts the cycle
    a_r6_cycle_after_data: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && st == ST_WDATA && lat_any && !wp_i && !busy) |=> busy);

endmodule

// File: tb/eep_slave_tb.sv
module eep_slave_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam int         AW         = 11;
    localparam int         WR         = 500;
    localparam logic [2:0] STRAP      = 3'b101;
    localparam logic [7:0] DEV_W      = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R      = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = ~(sda_oe | m_low);

    eep_slave #(.ADDR_W(AW), .WR_CYCLES(WR), .SYNC(2)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .wp_i    (wp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] exp_mem [1 << AW];
    logic [7:0] wbuf [80];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int amask(input int a);
        return a & ((1 << AW) - 1);
    endfunction

    function automatic int page_slot(input int base, input int k);
        return (amask(base) & ~63) | ((base + k) & 63);
    endfunction

    task automatic bus_start();
        tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_restart();
        m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i];
            tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
        end
        m_low = 1'b0;
        tick(Q); scl = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl = 1'b0; tick(Q);
        end
        m_low = give_ack;
        tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    task automatic poll(output bit ack);
        bus_start();
        send_byte(DEV_W, ack);
        bus_stop();
    endtask

    // writes n bytes of wbuf starting at a16, checks every acknowledge
    task automatic write_seq(input int a16, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(DEV_W, ack);               chk(ack, "R3 dev ack", ack, 1);
        send_byte(8'((a16 >> 8) & 255), ack); chk(ack, "R3 addr hi ack", ack, 1);
        send_byte(8'(a16 & 255), ack);       chk(ack, "R3 addr lo ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk(ack, req, ack, 1);
            if (!wp) exp_mem[page_slot(a16, k)] = wbuf[k];
        end
        bus_stop();
        chk(sda_line == 1'b1, "R12 line free after stop", sda_line, 1);
    endtask

    task automatic read_seq(input int a16, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'((a16 >> 8) & 255), ack);
        send_byte(8'(a16 & 255), ack);
        bus_restart();
        send_byte(DEV_R, ack);               chk(ack, "R9 read dev ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == exp_mem[amask(a16 + i)], req, b, exp_mem[amask(a16 + i)]);
        end
        tick(2);
        chk(sda_oe == 1'b0, "R11 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ack;
        int a, n;
        void'($urandom(32'd41));
        tick(5);
        rst = 1'b0;
        tick(3);
        chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
        poll(ack);
        chk(ack, "R1 idle after reset", ack, 1);

        // R2 address match
        bus_start(); send_byte(8'hA2, ack); bus_stop();
        chk(!ack, "R2 wrong strap", ack, 0);
        bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
        chk(!ack, "R2 wrong type", ack, 0);

        // neighbours, then byte write through junk upper address bits
        wbuf[0] = 8'h01; wbuf[1] = 8'h77; wbuf[2] = 8'h02;
        write_seq(16'h0122, 3, "R3 data ack");
        tick(WR + 50);
        wbuf[0] = 8'h5A;
        write_seq(16'hF923, 1, "R4 data ack");
        poll(ack);
        chk(!ack, "R7 busy refuses address", ack, 0);
        tick(WR);
        poll(ack);
        chk(ack, "R7 ready after cycle", ack, 1);
        read_seq(16'h0122, 3, "R5 R4 byte write and neighbours");

        // R8 write protect
        wp = 1'b1;
        wbuf[0] = 8'hA5;
        write_seq(16'h0123, 1, "R3 ack under protect");
        poll(ack);
        chk(ack, "R8 no cycle when protected", ack, 1);
        wp = 1'b0;
        read_seq(16'h0123, 1, "R8 data kept");

        // R6 page write with wrap and overwrite
        for (int k = 0; k < 70; k++) wbuf[k] = 8'($urandom & 255);
        write_seq(16'h0210, 70, "R6 page data ack");
        tick(WR + 50);
        read_seq(16'h0200, 64, "R6 R10 page image");

        // R10 wrap at top of array
        wbuf[0] = 8'h11;
        write_seq(16'h07FF, 1, "R10 top write");
        tick(WR + 50);
        wbuf[0] = 8'h22;
        write_seq(16'h0000, 1, "R10 bottom write");
        tick(WR + 50);
        read_seq(16'h07FF, 2, "R10 array wrap");

        // random byte runs, R5 R9
        for (int it = 0; it < 10; it++) begin
            a = 32'($urandom & 16'hFFFF);
            a = (a & ~63) | int'($urandom % 60);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom & 255);
            write_seq(a, n, "R5 random data ack");
            tick(WR + 50);
            read_seq(a, n, "R9 random readback");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule